// File: doc/BRIEF.md
# Radio Command State Sequencer

This controller sits between a host and the analog and digital control lines of a sub-GHz transceiver. The host hands it one 8-bit command opcode at a time over a valid/ready pair. The sequencer checks the opcode against the radio's current operating state, which is one of off, on, sleep, receive or transmit. It then plays out an ordered recipe of control actions that belongs to that exact pairing of opcode and state. Each action is either a one-cycle strobe or a change in the level of a control line.

Some actions take time: filter calibration, VCO calibration and the PA ramps. Each of these fires a strobe and then waits for the matching done input. A timeout bounds that wait. Synthesizer settling instead counts down a 16-bit value taken from a configuration input. Only after the last action does the reported state change and the block become ready again.

Illegal or unknown commands do nothing except raise a sticky flag, which the host clears with a read strobe. The block also captures two values: the channel word is latched onto a synthesizer output, and the RSSI sample is copied into a readback output.

Top module: `radio_seq_top`

## Requirements
- R1: Opcodes are 0xB0 (off), 0xB1 (on), 0xBA (sleep), 0xB2 (receive) and 0xB5 (transmit). The state codes are OFF=0, ON=1, SLEEP=2, RX=3 and TX=4. The legal pairings are: on from OFF, SLEEP, RX or TX; off from ON; sleep from OFF or ON; receive or transmit from ON, RX or TX. Any other accepted command, including an unknown opcode, leaves every output except `illegal_flag` unchanged.
- R2: `cmd_ready` is high exactly when `busy` is low. `busy` is high from the cycle after a legal accept until the cycle in which `state_out` takes its new value. `state_out` never changes while a command is in progress, and at most one strobe is high in any cycle.
- R3: `illegal_flag` rises the cycle after an illegal command is accepted. It stays high until a cycle with `status_rd` high, and it is low in the following cycle. `timeout_flag` follows the same clear rule.
- R4: On from OFF or SLEEP first raises `reg_en`. It then pulses `if_cal_go` and waits for `if_cal_done`, but only when `cfg_cal_on_up` is 1. The command ends in ON.
- R5: Off from ON, and sleep from OFF or ON, lower `reg_en` and end in OFF or SLEEP respectively.
- R6: On from TX, in order: `pa_down_go` and wait for `pa_ramp_done`, `pa_line` low, `tx_clk_en` low, `synth_en` low, then state ON.
- R7: On from RX, in order: `rssi_rb` is loaded from `rssi_in`, `lna_line` low, `rx_clk_en` low, `synth_en` and `rxchain_en` low together, then state ON.
- R8: Receive from ON, in order: `synth_en` high, `rxchain_en` high, `synth_chan` loaded from `chan_in`, `synth_bw_go`, `vco_cal_go` and wait for `vco_cal_done`, the settling wait, `rx_clk_en` high, `lna_line` high, then state RX.
- R9: Transmit from ON, in order: `synth_en` high, `synth_chan` loaded, `synth_bw_go`, VCO calibration, the settling wait, `tx_clk_en` high, `pa_line` high, `pa_up_go` and wait for `pa_ramp_done`, then state TX.
- R10: Receive from RX retunes: `lna_line` low, `rx_clk_en` low, then the channel, bandwidth, calibration and settling steps, then `rx_clk_en` high and `lna_line` high. Receive from TX first runs the PA ramp-down, `pa_line` low and `tx_clk_en` low, then raises `rxchain_en` before the same tuning and receive-enable steps. Transmit from TX runs the same ramp-down, then retunes and runs the transmit enable steps.
- R11: Transmit from RX, in order: `lna_line` low, `afc_agc_unlock_go`, `rx_clk_en` and `rxchain_en` low together, then the tuning steps and the transmit enable steps of R9. `rx_clk_en` and `tx_clk_en` are never high together.
- R12: `lna_line` and `pa_line` rise only while `cfg_lna_en` and `cfg_pa_en` respectively are 1. The steps that lower them always run.
- R13: The settling wait with `cfg_settle` = N lasts exactly N cycles longer than with `cfg_settle` = 0.
- R14: If a calibration or ramp done does not arrive within TMO_CYC cycles of its wait starting, `timeout_flag` is set and the recipe continues to its target state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 8 | Command opcode |
| cmd_ready | output | 1 | Command can be taken |
| cfg_cal_on_up | input | 1 | Run filter calibration on power-up |
| cfg_lna_en | input | 1 | External LNA line enable |
| cfg_pa_en | input | 1 | External PA line enable |
| cfg_settle | input | DLY_W | Synthesizer settling cycles |
| chan_in | input | CHAN_W | Channel word |
| rssi_in | input | RSSI_W | Measured RSSI |
| vco_cal_done | input | 1 | VCO calibration finished |
| if_cal_done | input | 1 | Filter calibration finished |
| pa_ramp_done | input | 1 | PA ramp finished |
| status_rd | input | 1 | Clears the sticky flags |
| state_out | output | 3 | Current radio state |
| busy | output | 1 | Recipe running |
| illegal_flag | output | 1 | Sticky illegal-command flag |
| timeout_flag | output | 1 | Sticky done-timeout flag |
| reg_en | output | 1 | RF and VCO regulators on |
| synth_en | output | 1 | Synthesizer powered |
| rxchain_en | output | 1 | Receiver analog chain powered |
| rx_clk_en | output | 1 | Digital receive blocks on |
| tx_clk_en | output | 1 | Digital transmit blocks on |
| lna_line | output | 1 | External LNA control line |
| pa_line | output | 1 | External PA control line |
| if_cal_go | output | 1 | Filter calibration strobe |
| vco_cal_go | output | 1 | VCO calibration strobe |
| synth_bw_go | output | 1 | Synthesizer bandwidth strobe |
| pa_up_go | output | 1 | PA ramp-up strobe |
| pa_down_go | output | 1 | PA ramp-down strobe |
| afc_agc_unlock_go | output | 1 | AFC/AGC unlock strobe |
| synth_chan | output | CHAN_W | Latched channel word |
| rssi_rb | output | RSSI_W | RSSI readback |

## Verification
The hardest states to reach from the ports are the mid-recipe ones: RX-to-TX and TX-to-RX switches, and retunes issued while already in RX or TX. Each exists only after earlier commands have carried the radio there with particular enable settings. The stimulus is a long random walk of mostly valid opcodes, with a few unknown bytes mixed in. Enables, settle counts, channel and RSSI values, and done latencies are redrawn for every command, so every transition is taken many times. A bench model predicts each recipe's observable event list. Directed runs then hold back a done pulse to force a timeout, and compare two settle counts to measure the settling wait exactly.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

    localparam logic [7:0] OP_OFF   = 8'hB0;
    localparam logic [7:0] OP_ON    = 8'hB1;
    localparam logic [7:0] OP_SLEEP = 8'hBA;
    localparam logic [7:0] OP_RX    = 8'hB2;
    localparam logic [7:0] OP_TX    = 8'hB5;

    localparam int STEP_SLOTS = 16;
    localparam int IDX_W      = $clog2(STEP_SLOTS);

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ON    = 3'd1,
        ST_SLEEP = 3'd2,
        ST_RX    = 3'd3,
        ST_TX    = 3'd4
    } radio_state_e;

    typedef enum logic [3:0] {
        RC_POWER_DOWN, RC_WAKE, RC_SLEEP, RC_TX_TO_ON, RC_RX_TO_ON,
        RC_ON_TO_RX, RC_RX_RETUNE, RC_TX_TO_RX, RC_ON_TO_TX,
        RC_RX_TO_TX, RC_TX_RETUNE
    } recipe_e;

    typedef enum logic [4:0] {
        S_DONE, S_REG_ON, S_REG_OFF, S_IFCAL, S_PA_DOWN, S_PA_LINE_LO,
        S_TXDIG_OFF, S_SYN_OFF, S_RSSI_CAP, S_LNA_LO, S_RXDIG_OFF,
        S_SYN_RX_OFF, S_SYN_ON, S_RXCH_ON, S_CHAN, S_BW, S_VCOCAL,
        S_SETTLE, S_RXDIG_ON, S_LNA_HI, S_TXDIG_ON, S_PA_LINE_HI,
        S_PA_UP, S_UNLOCK, S_RX_OFF
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_EXEC, PH_WAIT
    } phase_e;

    typedef struct packed {
        logic         legal;
        recipe_e      recipe;
        radio_state_e target;
    } decode_t;

    function automatic step_e recipe_step(recipe_e r, logic [IDX_W-1:0] i);
        step_e s [STEP_SLOTS];
        s = '{default: S_DONE};
        case (r)
            RC_POWER_DOWN: s = '{0: S_REG_OFF, default: S_DONE};
            RC_SLEEP:      s = '{0: S_REG_OFF, default: S_DONE};
            RC_WAKE:       s = '{0: S_REG_ON, 1: S_IFCAL, default: S_DONE};
            RC_TX_TO_ON:   s = '{0: S_PA_DOWN, 1: S_PA_LINE_LO, 2: S_TXDIG_OFF,
                                 3: S_SYN_OFF, default: S_DONE};
            RC_RX_TO_ON:   s = '{0: S_RSSI_CAP, 1: S_LNA_LO, 2: S_RXDIG_OFF,
                                 3: S_SYN_RX_OFF, default: S_DONE};
            RC_ON_TO_RX:   s = '{0: S_SYN_ON, 1: S_RXCH_ON, 2: S_CHAN, 3: S_BW,
                                 4: S_VCOCAL, 5: S_SETTLE, 6: S_RXDIG_ON,
                                 7: S_LNA_HI, default: S_DONE};
            RC_RX_RETUNE:  s = '{0: S_LNA_LO, 1: S_RXDIG_OFF, 2: S_CHAN, 3: S_BW,
                                 4: S_VCOCAL, 5: S_SETTLE, 6: S_RXDIG_ON,
                                 7: S_LNA_HI, default: S_DONE};
            RC_TX_TO_RX:   s = '{0: S_PA_DOWN, 1: S_PA_LINE_LO, 2: S_TXDIG_OFF,
                                 3: S_RXCH_ON, 4: S_CHAN, 5: S_BW, 6: S_VCOCAL,
                                 7: S_SETTLE, 8: S_RXDIG_ON, 9: S_LNA_HI,
                                 default: S_DONE};
            RC_ON_TO_TX:   s = '{0: S_SYN_ON, 1: S_CHAN, 2: S_BW, 3: S_VCOCAL,
                                 4: S_SETTLE, 5: S_TXDIG_ON, 6: S_PA_LINE_HI,
                                 7: S_PA_UP, default: S_DONE};
            RC_RX_TO_TX:   s = '{0: S_LNA_LO, 1: S_UNLOCK, 2: S_RX_OFF, 3: S_CHAN,
                                 4: S_BW, 5: S_VCOCAL, 6: S_SETTLE, 7: S_TXDIG_ON,
                                 8: S_PA_LINE_HI, 9: S_PA_UP, default: S_DONE};
            RC_TX_RETUNE:  s = '{0: S_PA_DOWN, 1: S_PA_LINE_LO, 2: S_TXDIG_OFF,
                                 3: S_CHAN, 4: S_BW, 5: S_VCOCAL, 6: S_SETTLE,
                                 7: S_TXDIG_ON, 8: S_PA_LINE_HI, 9: S_PA_UP,
                                 default: S_DONE};
            default:       s = '{default: S_DONE};
        endcase
        return s[i];
    endfunction

    function automatic logic step_waits(step_e s, logic cal_on);
        return (s == S_IFCAL && cal_on) || s == S_VCOCAL || s == S_PA_UP ||
               s == S_PA_DOWN || s == S_SETTLE;
    endfunction

endpackage

// File: rtl/rseq_decode.sv
module rseq_decode
    import radio_seq_pkg::*;
(
    input  logic [7:0]   op,
    input  radio_state_e cur,
    output decode_t      dec
);
    always_comb begin
        dec = '{legal: 1'b0, recipe: RC_POWER_DOWN, target: ST_OFF};
        case (op)
            OP_OFF: if (cur == ST_ON)
                dec = '{legal: 1'b1, recipe: RC_POWER_DOWN, target: ST_OFF};
            OP_SLEEP: if (cur == ST_ON || cur == ST_OFF)
                dec = '{legal: 1'b1, recipe: RC_SLEEP, target: ST_SLEEP};
            OP_ON: begin
                case (cur)
                    ST_OFF, ST_SLEEP: dec = '{legal: 1'b1, recipe: RC_WAKE,     target: ST_ON};
                    ST_TX:            dec = '{legal: 1'b1, recipe: RC_TX_TO_ON, target: ST_ON};
                    ST_RX:            dec = '{legal: 1'b1, recipe: RC_RX_TO_ON, target: ST_ON};
                    default: ;
                endcase
            end
            OP_RX: begin
                case (cur)
                    ST_ON: dec = '{legal: 1'b1, recipe: RC_ON_TO_RX,  target: ST_RX};
                    ST_RX: dec = '{legal: 1'b1, recipe: RC_RX_RETUNE, target: ST_RX};
                    ST_TX: dec = '{legal: 1'b1, recipe: RC_TX_TO_RX,  target: ST_RX};
                    default: ;
                endcase
            end
            OP_TX: begin
                case (cur)
                    ST_ON: dec = '{legal: 1'b1, recipe: RC_ON_TO_TX,  target: ST_TX};
                    ST_RX: dec = '{legal: 1'b1, recipe: RC_RX_TO_TX,  target: ST_TX};
                    ST_TX: dec = '{legal: 1'b1, recipe: RC_TX_RETUNE, target: ST_TX};
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rseq_wait.sv
module rseq_wait #(
    parameter int DLY_W   = 16,
    parameter int TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             use_delay,
    input  logic [DLY_W-1:0] delay_val,
    input  logic             done_in,
    output logic             fin,
    output logic             timed_out
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

    logic             active_q;
    logic             dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic [TMO_W-1:0] tmo_q;

    always_comb begin
        timed_out = active_q && !dly_q && !done_in && (tmo_q == TMO_LAST);
        if (!active_q)  fin = 1'b0;
        else if (dly_q) fin = (cnt_q == '0);
        else            fin = done_in || (tmo_q == TMO_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            dly_q    <= 1'b0;
            cnt_q    <= '0;
            tmo_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            dly_q    <= use_delay;
            cnt_q    <= delay_val;
            tmo_q    <= '0;
        end else if (fin) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (dly_q) cnt_q <= cnt_q - 1'b1;
            else       tmo_q <= tmo_q + 1'b1;
        end
    end

    // R14: the done wait never runs past its limit
    a_r14_tmo_bounded: assert property (@(posedge clk) disable iff (rst)
        (active_q && !dly_q) |-> (tmo_q <= TMO_LAST));
    // R13: settle counter drops by one each waiting cycle
    a_r13_settle_steps: assert property (@(posedge clk) disable iff (rst)
        (active_q && dly_q && cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/radio_seq_top.sv
module radio_seq_top
    import radio_seq_pkg::*;
#(
    parameter int CHAN_W  = 24,
    parameter int RSSI_W  = 8,
    parameter int DLY_W   = 16,
    parameter int TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    output logic              cmd_ready,
    input  logic              cfg_cal_on_up,
    input  logic              cfg_lna_en,
    input  logic              cfg_pa_en,
    input  logic [DLY_W-1:0]  cfg_settle,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic [RSSI_W-1:0] rssi_in,
    input  logic              vco_cal_done,
    input  logic              if_cal_done,
    input  logic              pa_ramp_done,
    input  logic              status_rd,
    output logic [2:0]        state_out,
    output logic              busy,
    output logic              illegal_flag,
    output logic              timeout_flag,
    output logic              reg_en,
    output logic              synth_en,
    output logic              rxchain_en,
    output logic              rx_clk_en,
    output logic              tx_clk_en,
    output logic              lna_line,
    output logic              pa_line,
    output logic              if_cal_go,
    output logic              vco_cal_go,
    output logic              synth_bw_go,
    output logic              pa_up_go,
    output logic              pa_down_go,
    output logic              afc_agc_unlock_go,
    output logic [CHAN_W-1:0] synth_chan,
    output logic [RSSI_W-1:0] rssi_rb
);
    phase_e             phase_q;
    radio_state_e       state_q, target_q;
    recipe_e            recipe_q;
    logic [IDX_W-1:0]   idx_q;
    decode_t            dec;
    step_e              cur_step;
    logic               wait_start, wait_fin, wait_tmo, done_sel;
    logic               accept;

    rseq_decode u_dec (
        .op  (cmd_op),
        .cur (state_q),
        .dec (dec)
    );

    assign cur_step   = recipe_step(recipe_q, idx_q);
    assign cmd_ready  = (phase_q == PH_IDLE);
    assign busy       = !cmd_ready;
    assign accept     = cmd_valid && cmd_ready;
    assign wait_start = (phase_q == PH_EXEC) && step_waits(cur_step, cfg_cal_on_up);
    assign state_out  = state_q;

    always_comb begin
        case (cur_step)
            S_IFCAL:            done_sel = if_cal_done;
            S_VCOCAL:           done_sel = vco_cal_done;
            S_PA_UP, S_PA_DOWN: done_sel = pa_ramp_done;
            default:            done_sel = 1'b0;
        endcase
    end

    rseq_wait #(.DLY_W(DLY_W), .TMO_CYC(TMO_CYC)) u_wait (
        .clk       (clk),
        .rst       (rst),
        .start     (wait_start),
        .use_delay (cur_step == S_SETTLE),
        .delay_val (cfg_settle),
        .done_in   (done_sel),
        .fin       (wait_fin),
        .timed_out (wait_tmo)
    );

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            state_q  <= ST_OFF;
            target_q <= ST_OFF;
            recipe_q <= RC_POWER_DOWN;
            idx_q    <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (accept && dec.legal) begin
                    recipe_q <= dec.recipe;
                    target_q <= dec.target;
                    idx_q    <= '0;
                    phase_q  <= PH_EXEC;
                end
                PH_EXEC: begin
                    if (cur_step == S_DONE) begin
                        state_q <= target_q;
                        phase_q <= PH_IDLE;
                    end else if (wait_start) begin
                        phase_q <= PH_WAIT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_WAIT: if (wait_fin) begin
                    idx_q   <= idx_q + 1'b1;
                    phase_q <= PH_EXEC;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // control actions
    always_ff @(posedge clk) begin
        if (rst) begin
            {reg_en, synth_en, rxchain_en, rx_clk_en, tx_clk_en, lna_line, pa_line} <= '0;
            {if_cal_go, vco_cal_go, synth_bw_go, pa_up_go, pa_down_go, afc_agc_unlock_go} <= '0;
            synth_chan <= '0;
            rssi_rb    <= '0;
        end else begin
            {if_cal_go, vco_cal_go, synth_bw_go, pa_up_go, pa_down_go, afc_agc_unlock_go} <= '0;
            if (phase_q == PH_EXEC) begin
                case (cur_step)
                    S_REG_ON:     reg_en <= 1'b1;
                    S_REG_OFF:    reg_en <= 1'b0;
                    S_IFCAL:      if_cal_go <= cfg_cal_on_up;
                    S_PA_DOWN:    pa_down_go <= 1'b1;
                    S_PA_LINE_LO: pa_line <= 1'b0;
                    S_TXDIG_OFF:  tx_clk_en <= 1'b0;
                    S_SYN_OFF:    synth_en <= 1'b0;
                    S_RSSI_CAP:   rssi_rb <= rssi_in;
                    S_LNA_LO:     lna_line <= 1'b0;
                    S_RXDIG_OFF:  rx_clk_en <= 1'b0;
                    S_SYN_RX_OFF: begin synth_en <= 1'b0; rxchain_en <= 1'b0; end
                    S_SYN_ON:     synth_en <= 1'b1;
                    S_RXCH_ON:    rxchain_en <= 1'b1;
                    S_CHAN:       synth_chan <= chan_in;
                    S_BW:         synth_bw_go <= 1'b1;
                    S_VCOCAL:     vco_cal_go <= 1'b1;
                    S_RXDIG_ON:   rx_clk_en <= 1'b1;
                    S_LNA_HI:     if (cfg_lna_en) lna_line <= 1'b1;
                    S_TXDIG_ON:   tx_clk_en <= 1'b1;
                    S_PA_LINE_HI: if (cfg_pa_en) pa_line <= 1'b1;
                    S_PA_UP:      pa_up_go <= 1'b1;
                    S_UNLOCK:     afc_agc_unlock_go <= 1'b1;
                    S_RX_OFF:     begin rx_clk_en <= 1'b0; rxchain_en <= 1'b0; end
                    default: ;
                endcase
            end
        end
    end

    // sticky flags
    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_flag <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            if (status_rd) begin
                illegal_flag <= 1'b0;
                timeout_flag <= 1'b0;
            end
            if (accept && !dec.legal)               illegal_flag <= 1'b1;
            if (phase_q == PH_WAIT && wait_tmo)    timeout_flag <= 1'b1;
        end
    end

    // R2: reported state moves only when a recipe finishes
    a_r2_state_on_finish: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_out) |-> $fell(busy));
    // R2: never two strobes at once
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({if_cal_go, vco_cal_go, synth_bw_go, pa_up_go, pa_down_go, afc_agc_unlock_go}));
    // R1: an illegal command starts nothing and raises the flag
    a_r1_illegal_flagged: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !dec.legal) |=> (illegal_flag && !busy));
    // R12: external lines rise only when enabled
    a_r12_lna_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(lna_line) |-> $past(cfg_lna_en));
    a_r12_pa_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(pa_line) |-> $past(cfg_pa_en));
    // R11: receive and transmit digital paths exclusive
    a_r11_clk_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rx_clk_en && tx_clk_en));
    // R6: PA line only with transmit path running
    a_r6_pa_needs_tx: assert property (@(posedge clk) disable iff (rst)
        pa_line |-> tx_clk_en);
endmodule

// File: tb/radio_seq_top_tb_top.sv
module radio_seq_top_tb_top;
    localparam int A_REG_ON = 1, A_REG_OFF = 2, A_IFCAL = 3, A_PA_DN = 4, A_PA_LO = 5,
                   A_TXD_OFF = 6, A_SYN_OFF = 7, A_RSSI = 8, A_LNA_LO = 9, A_RXD_OFF = 10,
                   A_SYNRX_OFF = 11, A_SYN_ON = 12, A_RXCH_ON = 13, A_CHAN = 14, A_BW = 15,
                   A_VCO = 16, A_SETTLE = 17, A_RXD_ON = 18, A_LNA_HI = 19, A_TXD_ON = 20,
                   A_PA_HI = 21, A_PA_UP = 22, A_UNLOCK = 23, A_RX_OFF = 24;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_ready;
    logic [7:0] cmd_op = 0;
    logic cfg_cal_on_up = 0, cfg_lna_en = 0, cfg_pa_en = 0;
    logic [15:0] cfg_settle = 0;
    logic [23:0] chan_in = 0;
    logic [7:0] rssi_in = 0;
    logic vco_cal_done = 0, if_cal_done = 0, pa_ramp_done = 0, status_rd = 0;
    logic [2:0] state_out;
    logic busy, illegal_flag, timeout_flag;
    logic reg_en, synth_en, rxchain_en, rx_clk_en, tx_clk_en, lna_line, pa_line;
    logic if_cal_go, vco_cal_go, synth_bw_go, pa_up_go, pa_down_go, afc_agc_unlock_go;
    logic [23:0] synth_chan;
    logic [7:0] rssi_rb;

    always #5 clk = ~clk;

    radio_seq_top dut_i (.*);

    int checks = 0, errors = 0;
    int mst = 0;                  // model state
    logic [6:0] mlv = '0;         // model levels
    logic [12:0] ev_q[$];
    logic [6:0] prev_lv = '0;
    int hold_done = 0, lat = 1, cd = 0, kind = 0;
    int last_cycles = 0;

    function automatic logic [6:0] obs_lv();
        return {reg_en, synth_en, rxchain_en, rx_clk_en, tx_clk_en, lna_line, pa_line};
    endfunction
    function automatic logic [5:0] obs_st();
        return {if_cal_go, vco_cal_go, synth_bw_go, pa_up_go, pa_down_go, afc_agc_unlock_go};
    endfunction

    // event monitor
    always @(negedge clk) begin
        if (!rst && (obs_st() != 0 || obs_lv() != prev_lv)) ev_q.push_back({obs_lv(), obs_st()});
        prev_lv = obs_lv();
    end

    // done responder
    always @(negedge clk) begin
        vco_cal_done = 0; if_cal_done = 0; pa_ramp_done = 0;
        if (cd != 0) begin
            cd--;
            if (cd == 0) begin
                if (kind == 1) if_cal_done = 1;
                else if (kind == 2) vco_cal_done = 1;
                else pa_ramp_done = 1;
            end
        end
        if (hold_done == 0 && (if_cal_go || vco_cal_go || pa_up_go || pa_down_go)) begin
            kind = if_cal_go ? 1 : (vco_cal_go ? 2 : 3);
            cd = lat;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // recipe list and target per requirements R1, R4..R11; target -1 when illegal
    task automatic plan(input int st, input logic [7:0] op, output int tgt, output int q[$]);
        q = {}; tgt = -1;
        case (op)
            8'hB0: if (st == 1) begin tgt = 0; q = {A_REG_OFF}; end
            8'hBA: if (st == 0 || st == 1) begin tgt = 2; q = {A_REG_OFF}; end
            8'hB1: case (st)
                0, 2: begin tgt = 1; q = {A_REG_ON, A_IFCAL}; end
                4: begin tgt = 1; q = {A_PA_DN, A_PA_LO, A_TXD_OFF, A_SYN_OFF}; end
                3: begin tgt = 1; q = {A_RSSI, A_LNA_LO, A_RXD_OFF, A_SYNRX_OFF}; end
                default: ;
            endcase
            8'hB2: case (st)
                1: begin tgt = 3; q = {A_SYN_ON, A_RXCH_ON, A_CHAN, A_BW, A_VCO, A_SETTLE, A_RXD_ON, A_LNA_HI}; end
                3: begin tgt = 3; q = {A_LNA_LO, A_RXD_OFF, A_CHAN, A_BW, A_VCO, A_SETTLE, A_RXD_ON, A_LNA_HI}; end
                4: begin tgt = 3; q = {A_PA_DN, A_PA_LO, A_TXD_OFF, A_RXCH_ON, A_CHAN, A_BW, A_VCO, A_SETTLE, A_RXD_ON, A_LNA_HI}; end
                default: ;
            endcase
            8'hB5: case (st)
                1: begin tgt = 4; q = {A_SYN_ON, A_CHAN, A_BW, A_VCO, A_SETTLE, A_TXD_ON, A_PA_HI, A_PA_UP}; end
                3: begin tgt = 4; q = {A_LNA_LO, A_UNLOCK, A_RX_OFF, A_CHAN, A_BW, A_VCO, A_SETTLE, A_TXD_ON, A_PA_HI, A_PA_UP}; end
                4: begin tgt = 4; q = {A_PA_DN, A_PA_LO, A_TXD_OFF, A_CHAN, A_BW, A_VCO, A_SETTLE, A_TXD_ON, A_PA_HI, A_PA_UP}; end
                default: ;
            endcase
            default: ;
        endcase
    endtask

    function automatic string req_of(int st, logic [7:0] op, int tgt);
        if (tgt < 0) return "R1";
        if (op == 8'hB0 || op == 8'hBA) return "R5";
        if (op == 8'hB1) return (st == 4) ? "R6" : (st == 3) ? "R7" : "R4";
        if (op == 8'hB2) return (st == 1) ? "R8" : "R10";
        return (st == 1) ? "R9" : (st == 3) ? "R11" : "R10";
    endfunction

    // levels {reg,syn,rxch,rxclk,txclk,lna,pa}, strobes {ifcal,vco,bw,up,dn,unlock}
    task automatic expect_events(input int q[$], output logic [12:0] exp[$]);
        exp = {};
        foreach (q[k]) begin
            logic [6:0] old = mlv;
            logic [5:0] s = '0;
            case (q[k])
                A_REG_ON: mlv[6] = 1;            A_REG_OFF: mlv[6] = 0;
                A_IFCAL: if (cfg_cal_on_up) s[5] = 1;
                A_PA_DN: s[1] = 1;               A_PA_LO: mlv[0] = 0;
                A_TXD_OFF: mlv[2] = 0;           A_SYN_OFF: mlv[5] = 0;
                A_LNA_LO: mlv[1] = 0;            A_RXD_OFF: mlv[3] = 0;
                A_SYNRX_OFF: begin mlv[5] = 0; mlv[4] = 0; end
                A_SYN_ON: mlv[5] = 1;            A_RXCH_ON: mlv[4] = 1;
                A_BW: s[3] = 1;                  A_VCO: s[4] = 1;
                A_RXD_ON: mlv[3] = 1;            A_LNA_HI: if (cfg_lna_en) mlv[1] = 1;
                A_TXD_ON: mlv[2] = 1;            A_PA_HI: if (cfg_pa_en) mlv[0] = 1;
                A_PA_UP: s[2] = 1;               A_UNLOCK: s[0] = 1;
                A_RX_OFF: begin mlv[3] = 0; mlv[4] = 0; end
                default: ;
            endcase
            if (s != 0 || mlv != old) exp.push_back({mlv, s});
        end
    endtask

    task automatic clear_flags();
        @(negedge clk) status_rd = 1;
        @(negedge clk) status_rd = 0;
    endtask

    task automatic run_cmd(input logic [7:0] op, input int exp_tmo);
        int tgt, q[$], st0, stable_ok;
        logic [12:0] exp[$];
        string rq;
        st0 = mst;
        plan(st0, op, tgt, q);
        rq = req_of(st0, op, tgt);
        @(negedge clk);
        ev_q = {};
        expect_events(q, exp);
        cmd_op = op; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        check("R2", "busy after accept", busy, tgt >= 0);
        check("R2", "ready is not busy", cmd_ready, !busy);
        stable_ok = 1; last_cycles = 0;
        while (busy) begin
            if (state_out != st0 || cmd_ready) stable_ok = 0;
            last_cycles++;
            @(negedge clk);
        end
        check("R2", "state held while busy", stable_ok, 1);
        if (tgt >= 0) mst = tgt;
        check(rq, "final state", state_out, mst);
        check(rq, "event count", ev_q.size(), exp.size());
        if (ev_q.size() == exp.size())
            foreach (exp[k]) check(rq, $sformatf("event %0d", k), ev_q[k], exp[k]);
        if (q.size() != 0 && A_CHAN inside {q}) check(rq, "channel latched", synth_chan, chan_in);
        if (tgt >= 0 && st0 == 3 && op == 8'hB1) check("R7", "rssi readback", rssi_rb, rssi_in);
        check("R3", "illegal flag", illegal_flag, tgt < 0);
        check("R14", "timeout flag", timeout_flag, exp_tmo);
        if (illegal_flag || timeout_flag) begin
            clear_flags();
            check("R3", "flags cleared by read", {illegal_flag, timeout_flag}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, seed_v;
        logic [7:0] ops [5] = '{8'hB0, 8'hB1, 8'hBA, 8'hB2, 8'hB5};
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", "reset state OFF", state_out, 0);
        check("R2", "reset ready", cmd_ready, 1);
        check("R2", "reset busy", busy, 0);
        check("R3", "reset flags", {illegal_flag, timeout_flag}, 0);
        check("R5", "reset levels", obs_lv(), 0);

        // directed: illegal pairings
        run_cmd(8'hB5, 0);                 // R1 transmit from OFF
        run_cmd(8'h00, 0);                 // R1 unknown opcode
        // R4 without and with filter calibration
        cfg_cal_on_up = 0; run_cmd(8'hB1, 0);
        run_cmd(8'hB0, 0);
        cfg_cal_on_up = 1; lat = 3; run_cmd(8'hB1, 0);
        // R13 settle length
        cfg_settle = 0; lat = 2; cfg_lna_en = 1; chan_in = 24'h123456;
        run_cmd(8'hB2, 0); t0 = last_cycles;
        rssi_in = 8'h5A; run_cmd(8'hB1, 0);
        cfg_settle = 7; run_cmd(8'hB2, 0);
        check("R13", "settle adds N cycles", last_cycles - t0, 7);
        run_cmd(8'hBA, 0);                 // R1 sleep from RX illegal
        // R11 and R12 with PA line disabled
        cfg_pa_en = 0; run_cmd(8'hB5, 0);
        // R14 timeout on PA ramp-down
        hold_done = 1; run_cmd(8'hB1, 1); hold_done = 0;

        // random walk
        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            op = ($urandom_range(0, 9) == 0) ? 8'($urandom) : ops[$urandom_range(0, 4)];
            cfg_cal_on_up = 1'($urandom);
            cfg_lna_en = 1'($urandom);
            cfg_pa_en = 1'($urandom);
            cfg_settle = 16'($urandom_range(0, 20));
            chan_in = 24'($urandom);
            rssi_in = 8'($urandom);
            lat = $urandom_range(1, 5);
            run_cmd(op, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule